// File: doc/BRIEF.md
# External Data Memory Access Controller

This block sits between an 8-bit processor core and a byte-wide external data memory reached over a 24-bit address bus, so up to 16 MB is addressable. It keeps the address registers the core loads before an access: a three-byte data pointer (low, high and a page byte that selects a 64 KB segment) and an upper-address byte for accesses where an 8-bit register supplies only the low address byte. When the core raises a request, the controller forms the full address, drives either a read or a write strobe for a programmable number of clocks, and returns a one-cycle completion pulse with the read byte.

Strobe length comes from a 3-bit stretch register, so slow devices can get up to eight clocks of strobe without changing the core. The address and write data are latched when the request is taken and held through the access. A drive-enable output tells external tri-state buffers when the controller owns the data bus.

Top module: `xmem_access_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every address register, the stretch value, the address, write data and read data outputs, both strobes, the drive enable, busy and done.
- R2: With cfg_we high, cfg_sel selects the register loaded from cfg_wdata: 0 pointer low, 1 pointer high, 2 page, 3 upper byte, 4 stretch (bits 2:0). Codes 5, 6 and 7 change nothing.
- R3: A request with req_ind low uses the address {page, pointer high, pointer low}, with the page in bits 23:16.
- R4: A request with req_ind high uses the address {page, upper byte, req_lo}.
- R5: A request taken while idle starts its strobe in the next cycle. The strobe lasts stretch+1 cycles. Reads use only xrd and writes use only xwr, and the two are never high together.
- R6: Read data is sampled from xrdata in the last strobe cycle. It appears on rdata in the cycle after the strobe ends and stays there until the next read completes.
- R7: A write puts req_wdata on xwdata. xdata_oe is high for exactly the write strobe cycles and low from the cycle after the strobe ends.
- R8: xaddr and xwdata stay unchanged from the first strobe cycle through the done cycle. Register writes made during an access do not alter them.
- R9: busy is high from the first strobe cycle through the done cycle. Requests seen while busy is high are not taken. A request held into the cycle after done starts a new access.
- R10: done is high for exactly one cycle per access, reads and writes alike, in the cycle right after the strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 8 | Register write data |
| req | input | 1 | Access request |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ind | input | 1 | 1 = 8-bit register addressing, 0 = data pointer |
| req_lo | input | 8 | Low address byte for register addressing |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| xaddr | output | 24 | External address |
| xwdata | output | 8 | External write data |
| xrdata | input | 8 | External read data |
| xrd | output | 1 | Read strobe |
| xwr | output | 1 | Write strobe |
| xdata_oe | output | 1 | Write data bus drive enable |

## Verification
Reads and writes are run at stretch values 0, 3 and 7. The read data input changes on every clock, so a capture taken one cycle early or late gives a wrong byte, and a strobe that is one cycle too long or short shows up at once. Page, pointer and upper-byte values are chosen distinct so that swapped bytes or a wrong addressing source produce a different address. Register writes made during an access, writes with unused select codes, and requests held through the whole access test that changes are taken only at the right moment and that the address is held. A request held past done tests that the next access starts in the cycle after done.

// File: rtl/xmem_pkg.sv
`timescale 1ns/1ps
package xmem_pkg;

  typedef enum logic [2:0] {
    CFG_PTR_LO  = 3'd0,
    CFG_PTR_HI  = 3'd1,
    CFG_PAGE    = 3'd2,
    CFG_UPPER   = 3'd3,
    CFG_STRETCH = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STROBE = 2'd1,
    SEQ_DONE   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/xmem_cfg_regs.sv
`timescale 1ns/1ps
module xmem_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int STR_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] ptr_lo,
  output logic [DATA_W-1:0] ptr_hi,
  output logic [DATA_W-1:0] page,
  output logic [DATA_W-1:0] upper,
  output logic [STR_W-1:0]  stretch
);
  import xmem_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_lo  <= '0;
      ptr_hi  <= '0;
      page    <= '0;
      upper   <= '0;
      stretch <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        CFG_PTR_LO:  ptr_lo  <= cfg_wdata;
        CFG_PTR_HI:  ptr_hi  <= cfg_wdata;
        CFG_PAGE:    page    <= cfg_wdata;
        CFG_UPPER:   upper   <= cfg_wdata;
        CFG_STRETCH: stretch <= cfg_wdata[STR_W-1:0];
        default: ;
      endcase
    end
  end

  // R1: reset leaves every register at zero
  a_r1_regs_cleared: assert property (@(posedge clk)
    rst |=> (ptr_lo == '0 && ptr_hi == '0 && page == '0 && upper == '0 && stretch == '0));

  // R2: unused select codes leave all registers untouched
  a_r2_unused_code: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel > 3'd4) |=> ($stable(ptr_lo) && $stable(ptr_hi) && $stable(page)
                                    && $stable(upper) && $stable(stretch)));

endmodule

// File: rtl/xmem_addr_mux.sv
`timescale 1ns/1ps
module xmem_addr_mux #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 3 * DATA_W
) (
  input  logic              use_ind,
  input  logic [DATA_W-1:0] ind_lo,
  input  logic [DATA_W-1:0] ptr_lo,
  input  logic [DATA_W-1:0] ptr_hi,
  input  logic [DATA_W-1:0] page,
  input  logic [DATA_W-1:0] upper,
  output logic [ADDR_W-1:0] addr
);
  logic [DATA_W-1:0] mid_byte;
  logic [DATA_W-1:0] low_byte;

  always_comb begin
    mid_byte = use_ind ? upper  : ptr_hi;
    low_byte = use_ind ? ind_lo : ptr_lo;
    addr     = {page, mid_byte, low_byte};
  end

endmodule

// File: rtl/xmem_seq.sv
`timescale 1ns/1ps
module xmem_seq #(
  parameter int DATA_W = 8,
  parameter int STR_W  = 3,
  localparam int ADDR_W = 3 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [STR_W-1:0]  stretch,
  input  logic [DATA_W-1:0] xrdata,
  output logic [ADDR_W-1:0] xaddr,
  output logic [DATA_W-1:0] xwdata,
  output logic              xrd,
  output logic              xwr,
  output logic              xdata_oe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  import xmem_pkg::*;

  seq_state_e           state;
  logic [STR_W-1:0]     remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      remain   <= '0;
      xaddr    <= '0;
      xwdata   <= '0;
      xrd      <= 1'b0;
      xwr      <= 1'b0;
      xdata_oe <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req) begin
            state    <= SEQ_STROBE;
            remain   <= stretch;
            xaddr    <= next_addr;
            xrd      <= !req_wr;
            xwr      <= req_wr;
            xdata_oe <= req_wr;
            busy     <= 1'b1;
            if (req_wr) xwdata <= req_wdata;
          end
        end
        SEQ_STROBE: begin
          if (remain == '0) begin
            state    <= SEQ_DONE;
            xrd      <= 1'b0;
            xwr      <= 1'b0;
            xdata_oe <= 1'b0;
            done     <= 1'b1;
            if (xrd) rdata <= xrdata;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        SEQ_DONE: begin
          state <= SEQ_IDLE;
          busy  <= 1'b0;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Checker state: measured strobe length and the length asked for
  logic [STR_W:0]   run_len;
  logic [STR_W-1:0] want_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len  <= '0;
      want_len <= '0;
    end else begin
      run_len <= (xrd || xwr) ? run_len + 1'b1 : '0;
      if (state == SEQ_IDLE && req) want_len <= stretch;
    end
  end

  // R5: the strobe lasts stretch+1 cycles
  a_r5_width: assert property (@(posedge clk) disable iff (rst)
    $fell(xrd || xwr) |-> (run_len == {1'b0, want_len} + 1'b1));

  // R5: read and write strobes never overlap
  a_r5_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(xrd && xwr));

  // R7: bus driven only while the write strobe is high
  a_r7_oe_write: assert property (@(posedge clk) disable iff (rst)
    xdata_oe |-> xwr);

  // R8: address and write data hold through the strobe and the done cycle
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (xrd || xwr) |=> ($stable(xaddr) && $stable(xwdata)));

  // R10: done follows immediately after a strobe ends
  a_r10_done_after: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(xrd || xwr) && !(xrd || xwr)));

  // R9: busy drops right after the done cycle
  a_r9_busy_drop: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

endmodule

// File: rtl/xmem_access_ctrl.sv
`timescale 1ns/1ps
module xmem_access_ctrl #(
  parameter int DATA_W = 8,
  parameter int STR_W  = 3,
  localparam int ADDR_W = 3 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_ind,
  input  logic [DATA_W-1:0] req_lo,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] xaddr,
  output logic [DATA_W-1:0] xwdata,
  input  logic [DATA_W-1:0] xrdata,
  output logic              xrd,
  output logic              xwr,
  output logic              xdata_oe
);
  logic [DATA_W-1:0] ptr_lo, ptr_hi, page, upper;
  logic [STR_W-1:0]  stretch;
  logic [ADDR_W-1:0] next_addr;

  xmem_cfg_regs #(.DATA_W(DATA_W), .STR_W(STR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .page(page), .upper(upper), .stretch(stretch)
  );

  xmem_addr_mux #(.DATA_W(DATA_W)) u_mux (
    .use_ind(req_ind), .ind_lo(req_lo), .ptr_lo(ptr_lo), .ptr_hi(ptr_hi),
    .page(page), .upper(upper), .addr(next_addr)
  );

  xmem_seq #(.DATA_W(DATA_W), .STR_W(STR_W)) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .next_addr(next_addr),
    .req_wdata(req_wdata), .stretch(stretch), .xrdata(xrdata),
    .xaddr(xaddr), .xwdata(xwdata), .xrd(xrd), .xwr(xwr), .xdata_oe(xdata_oe),
    .busy(busy), .done(done), .rdata(rdata)
  );

endmodule

// File: tb/xmem_access_ctrl_bench.sv
`timescale 1ns/1ps
module xmem_access_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req = 1'b0, req_wr = 1'b0, req_ind = 1'b0;
  logic [7:0]  req_lo = '0, req_wdata = '0;
  logic        busy, done, xrd, xwr, xdata_oe;
  logic [7:0]  rdata, xwdata, xrdata;
  logic [23:0] xaddr;
  logic [7:0]  tick = '0;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  xmem_access_ctrl u_xmem_access_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .req_wr(req_wr), .req_ind(req_ind), .req_lo(req_lo), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .xaddr(xaddr), .xwdata(xwdata),
    .xrdata(xrdata), .xrd(xrd), .xwr(xwr), .xdata_oe(xdata_oe)
  );

  // Memory stand-in: the returned byte depends on the address and on a value
  // that changes every clock, so the capture cycle is visible.
  function automatic logic [7:0] mem_byte(input logic [23:0] a, input logic [7:0] t);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ t ^ 8'h3C;
  endfunction

  always @(negedge clk) tick <= tick + 8'd1;
  assign xrdata = mem_byte(xaddr, tick);

  // Reference model
  logic [7:0]  m_lo = '0, m_hi = '0, m_pg = '0, m_up = '0;
  int          m_st = 0;
  int          m_phase = 0;   // 0 waiting, 1 strobing, 2 finishing
  int          m_left = 0;
  logic [23:0] m_addr = '0;
  logic [7:0]  m_wdata = '0, m_rdata = '0;
  logic        m_rd = 0, m_wr = 0, m_oe = 0, m_busy = 0, m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_lo = '0; m_hi = '0; m_pg = '0; m_up = '0; m_st = 0;
      m_phase = 0; m_left = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
      m_rd = 0; m_wr = 0; m_oe = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_phase == 0) begin
        if (req) begin
          m_phase = 1;
          m_left  = m_st + 1;
          m_addr  = req_ind ? {m_pg, m_up, req_lo} : {m_pg, m_hi, m_lo};
          m_rd = !req_wr; m_wr = req_wr; m_oe = req_wr; m_busy = 1;
          if (req_wr) m_wdata = req_wdata;
        end
      end else if (m_phase == 1) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          if (m_rd) m_rdata = mem_byte(m_addr, tick);
          m_rd = 0; m_wr = 0; m_oe = 0; m_done = 1; m_phase = 2;
        end
      end else begin
        m_phase = 0; m_busy = 0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_lo = cfg_wdata;
          3'd1: m_hi = cfg_wdata;
          3'd2: m_pg = cfg_wdata;
          3'd3: m_up = cfg_wdata;
          3'd4: m_st = int'(cfg_wdata[2:0]);
          default: ;   // R2: codes 5..7 do nothing
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
    end
  endtask

  // Compare every clock, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    chk("R3/R4/R8 xaddr", 32'(xaddr), 32'(m_addr));
    chk("R7/R8 xwdata", 32'(xwdata), 32'(m_wdata));
    chk("R5 xrd", 32'(xrd), 32'(m_rd));
    chk("R5 xwr", 32'(xwr), 32'(m_wr));
    chk("R7 xdata_oe", 32'(xdata_oe), 32'(m_oe));
    chk("R9 busy", 32'(busy), 32'(m_busy));
    chk("R10 done", 32'(done), 32'(m_done));
    chk("R6 rdata", 32'(rdata), 32'(m_rdata));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic cfg(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic wr, input logic ind, input logic [7:0] lo,
                        input logic [7:0] wd, input int hold);
    @(negedge clk);
    while (m_busy) @(negedge clk);
    req = 1'b1; req_wr = wr; req_ind = ind; req_lo = lo; req_wdata = wd;
    for (int i = 0; i < hold; i++) @(negedge clk);
    req = 1'b0;
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: every output is zero during reset
    chk("R1 reset xaddr", 32'(xaddr), 32'h0);
    chk("R1 reset strobes", 32'({xrd, xwr, xdata_oe, busy, done}), 32'h0);
    rst = 1'b0;

    // R5 at stretch 0: single-cycle pointer read, then a write
    access(1'b0, 1'b0, 8'h00, 8'h00, 1);
    cfg(3'd0, 8'h12); cfg(3'd1, 8'h34); cfg(3'd2, 8'h56); cfg(3'd3, 8'h9A);
    access(1'b0, 1'b0, 8'h00, 8'h00, 1);              // R3
    access(1'b1, 1'b0, 8'h00, 8'hC3, 1);              // R7
    access(1'b0, 1'b1, 8'h7E, 8'h00, 1);              // R4

    // R2: unused codes change nothing
    cfg(3'd5, 8'hFF); cfg(3'd6, 8'hEE); cfg(3'd7, 8'hDD);
    access(1'b0, 1'b0, 8'h00, 8'h00, 1);

    // R5/R6 at the longest strobe
    cfg(3'd4, 8'hFF);
    access(1'b0, 1'b0, 8'h00, 8'h00, 1);
    access(1'b1, 1'b1, 8'h41, 8'h5A, 1);

    // R8: register writes during an access
    cfg(3'd4, 8'h03);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; req_ind = 1'b0;
    @(negedge clk);
    req = 1'b0;
    cfg_we = 1'b1; cfg_sel = 3'd2; cfg_wdata = 8'hA7;
    @(negedge clk);
    cfg_sel = 3'd0; cfg_wdata = 8'h01;
    @(negedge clk);
    cfg_we = 1'b0;
    while (m_busy) @(negedge clk);
    access(1'b0, 1'b0, 8'h00, 8'h00, 1);              // R3 new page

    // R9: request held through a whole access and past done
    access(1'b1, 1'b0, 8'h00, 8'h66, 7);
    access(1'b0, 1'b1, 8'h10, 8'h00, 1);

    // R10: done pulses with stretch 0 again, back-to-back pointer reads
    cfg(3'd4, 8'h00);
    access(1'b0, 1'b0, 8'h00, 8'h00, 4);
    repeat (4) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule